// File: doc/BRIEF.md
# Register Array with Arithmetic Unit

This block is the 16-bit working core of a microcoded processor. It holds an array of 32 general registers and an arithmetic unit. In one clock cycle it reads two operands, applies one of four functions, shows the result on an output bus and can write that result back into the array. Four status flags record the outcome: carry, signed overflow, sign and zero.

The operand addresses are not wired straight to the array. Each one passes through a small selector that picks one of two register-number fields, which normally come from the pipeline register of the sequencer. The function code and the carry-in are chosen separately. Because of this, the single "B plus carry" function gives a plain move when the carry-in is 0 and an increment when it is 1, so a program counter can advance by one in a single cycle. A data input can stand in for the B operand, and this is how values from outside reach the array.

Top module: `regalu_top`

## Requirements
- R1: While reset (rstN low) is asserted, all 32 registers and all four flags are cleared to 0.
- R2: With aAddrSel = 0 the A operand is the register named by regaField. With aAddrSel = 1 it is the register named by regbField.
- R3: With bAddrSel = 0 the field regaField supplies both the B read address and the write-back address. With bAddrSel = 1 the field regbField supplies both.
- R4: funcSel = 0 outputs the B operand unchanged, whatever the carry-in.
- R5: funcSel = 1 outputs B + Cin. With Cin = 0 this is a move; with Cin = 1 it is an increment.
- R6: funcSel = 2 outputs A + B + Cin.
- R7: funcSel = 3 outputs B + ~A + Cin, which is B − A when Cin = 1. Example: B = 0x7FFF, A = 0x0001 gives 0x7FFE.
- R8: cinSel chooses the carry-in: 0 gives 0, 1 gives 1, 2 gives the stored carry flag, 3 gives the inverted stored carry flag.
- R9: With bSrcSel = 1 the B operand is dataIn instead of the register value.
- R10: Register reads are combinational. dOut is written to the addressed register on the rising clock edge when wrEn = 1. When wrEn = 0 no register changes.
- R11: When flagEn = 1, the flags are loaded at the rising edge as follows. The flags do not change when flagEn = 0.
  - C is the adder carry-out.
  - V is set when the two adder inputs have the same sign and the result sign differs from it.
  - S is result bit 15.
  - Z is set when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| regaField | input | 5 | First register-number field |
| regbField | input | 5 | Second register-number field |
| aAddrSel | input | 1 | Selects the A operand address field |
| bAddrSel | input | 1 | Selects the B read and write-back address field |
| funcSel | input | 2 | Function code |
| cinSel | input | 2 | Carry-in source |
| bSrcSel | input | 1 | B operand source: register or dataIn |
| dataIn | input | 16 | External operand |
| wrEn | input | 1 | Write-back enable |
| flagEn | input | 1 | Flag update enable |
| dOut | output | 16 | Function result |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| flagS | output | 1 | Sign flag |
| flagZ | output | 1 | Zero flag |

## Verification
The carry-in choices that read the stored carry are the hardest to reach. They only mean something once an earlier operation has left a known carry in the flag register. The vector walk therefore places a subtraction that produces a carry just before the stored-carry and inverted-carry cases, and their expected outputs depend on that history. Signed overflow in both directions is reached the same way. First a pass-through and an addition build the operands 0x7FFF and 0x8000 in the array, and only then are the overflowing add and subtract applied.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_INC  = 2'd1,
    FN_ADD  = 2'd2,
    FN_SUB  = 2'd3
  } func_e;

  typedef enum logic [1:0] {
    CI_ZERO   = 2'd0,
    CI_ONE    = 2'd1,
    CI_CARRY  = 2'd2,
    CI_NCARRY = 2'd3
  } cinsel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    func_e func;
    logic  cin;
    logic  useDin;
    logic  wrEn;
    logic  flagEn;
  } strobe_t;
endpackage

// File: rtl/regalu_ctrl.sv
module regalu_ctrl
  import regalu_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regaField,
  input  logic [ADDR_W-1:0] regbField,
  input  logic              aAddrSel,
  input  logic              bAddrSel,
  input  logic [1:0]        funcSel,
  input  logic [1:0]        cinSel,
  input  logic              bSrcSel,
  input  logic              wrEn,
  input  logic              flagEn,
  input  logic              carryFlag,
  output logic [ADDR_W-1:0] aAddr,
  output logic [ADDR_W-1:0] bAddr,
  output strobe_t           strobes
);
  logic cinVal;

  always_comb begin
    unique case (cinsel_e'(cinSel))
      CI_ZERO:   cinVal = 1'b0;
      CI_ONE:    cinVal = 1'b1;
      CI_CARRY:  cinVal = carryFlag;
      CI_NCARRY: cinVal = ~carryFlag;
      default:   cinVal = 1'b0;
    endcase
  end

  // operand address selectors
  assign aAddr = aAddrSel ? regbField : regaField;
  assign bAddr = bAddrSel ? regbField : regaField;

  always_comb begin
    strobes.func   = func_e'(funcSel);
    strobes.cin    = cinVal;
    strobes.useDin = bSrcSel;
    strobes.wrEn   = wrEn;
    strobes.flagEn = flagEn;
  end
endmodule

// File: rtl/regalu_dpath.sv
module regalu_dpath
  import regalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] result,
  output logic              flagC,
  output logic              flagV,
  output logic              flagS,
  output logic              flagZ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [DATA_W-1:0] aOp, bOp, xIn, yIn;
  logic              ciIn;
  logic [DATA_W:0]   sum;
  logic              carryOut, ovf;

  assign aOp = regs[aAddr];
  assign bOp = strobes.useDin ? dataIn : regs[bAddr];

  always_comb begin
    unique case (strobes.func)
      FN_PASS: begin xIn = bOp; yIn = '0;   ciIn = 1'b0;        end
      FN_INC:  begin xIn = bOp; yIn = '0;   ciIn = strobes.cin; end
      FN_ADD:  begin xIn = aOp; yIn = bOp;  ciIn = strobes.cin; end
      FN_SUB:  begin xIn = bOp; yIn = ~aOp; ciIn = strobes.cin; end
      default: begin xIn = bOp; yIn = '0;   ciIn = 1'b0;        end
    endcase
    sum = {1'b0, xIn} + {1'b0, yIn} + {{DATA_W{1'b0}}, ciIn};
  end

  assign result   = sum[DATA_W-1:0];
  assign carryOut = sum[DATA_W];
  assign ovf      = (xIn[DATA_W-1] == yIn[DATA_W-1]) &&
                    (result[DATA_W-1] != xIn[DATA_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (strobes.wrEn) begin
      regs[bAddr] <= result;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC <= 1'b0;
      flagV <= 1'b0;
      flagS <= 1'b0;
      flagZ <= 1'b0;
    end else if (strobes.flagEn) begin
      flagC <= carryOut;
      flagV <= ovf;
      flagS <= result[DATA_W-1];
      flagZ <= (result == '0);
    end
  end

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.func == FN_PASS) |-> (result == bOp));

  // R10
  writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (regs[$past(bAddr)] == $past(result)));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagEn |=> ($stable(flagC) && $stable(flagV) && $stable(flagS) && $stable(flagZ)));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagEn |=> (flagZ == ($past(result) == '0)));

  // R11
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagEn |=> (flagS == $past(result[DATA_W-1])));
endmodule

// File: rtl/regalu_top.sv
module regalu_top
  import regalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regaField,
  input  logic [ADDR_W-1:0] regbField,
  input  logic              aAddrSel,
  input  logic              bAddrSel,
  input  logic [1:0]        funcSel,
  input  logic [1:0]        cinSel,
  input  logic              bSrcSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wrEn,
  input  logic              flagEn,
  output logic [DATA_W-1:0] dOut,
  output logic              flagC,
  output logic              flagV,
  output logic              flagS,
  output logic              flagZ
);
  logic [ADDR_W-1:0] aAddr, bAddr;
  strobe_t           strobes;

  regalu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regaField(regaField), .regbField(regbField),
    .aAddrSel(aAddrSel), .bAddrSel(bAddrSel),
    .funcSel(funcSel), .cinSel(cinSel), .bSrcSel(bSrcSel),
    .wrEn(wrEn), .flagEn(flagEn), .carryFlag(flagC),
    .aAddr(aAddr), .bAddr(bAddr), .strobes(strobes)
  );

  regalu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .aAddr(aAddr), .bAddr(bAddr),
    .strobes(strobes), .dataIn(dataIn), .result(dOut),
    .flagC(flagC), .flagV(flagV), .flagS(flagS), .flagZ(flagZ)
  );
endmodule

// File: tb/tb_regalu_top.sv
module tb_regalu_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  regaField, regbField;
  logic        aAddrSel, bAddrSel, bSrcSel, wrEn, flagEn;
  logic [1:0]  funcSel, cinSel;
  logic [15:0] dataIn, dOut;
  logic        flagC, flagV, flagS, flagZ;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  regalu_top dut (.*);

  typedef struct packed {
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic        aS;
    logic        bS;
    logic [1:0]  fn;
    logic [1:0]  cs;
    logic        ud;
    logic [15:0] din;
    logic        wr;
    logic [15:0] expOut;
    logic [3:0]  expFl;   // {C,V,S,Z}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R9 loads through dataIn
    '{5'd1, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 16'h7FFF, 1'b1, 16'h7FFF, 4'b0000, 4'd9},
    '{5'd2, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 16'h0001, 1'b1, 16'h0001, 4'b0000, 4'd9},
    '{5'd3, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF, 4'b0010, 4'd9},
    // R7 B=R1 minus A=R2
    '{5'd1, 5'd2, 1'b1, 1'b0, 2'd3, 2'd1, 1'b0, 16'h0000, 1'b0, 16'h7FFE, 4'b1000, 4'd7},
    // R8 stored carry (1), then inverted carry (0 -> 1)
    '{5'd2, 5'd0, 1'b0, 1'b0, 2'd1, 2'd2, 1'b0, 16'h0000, 1'b0, 16'h0002, 4'b0000, 4'd8},
    '{5'd2, 5'd0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b0, 16'h0000, 1'b0, 16'h0002, 4'b0000, 4'd8},
    // R5 increment R3 wraps, move with Cin 0
    '{5'd3, 5'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 16'h0000, 1'b1, 16'h0000, 4'b1001, 4'd5},
    '{5'd1, 5'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h7FFF, 4'b0000, 4'd5},
    // R6 positive overflow
    '{5'd1, 5'd0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 16'hFFFE, 4'b0110, 4'd6},
    // R4 pass ignores Cin 1
    '{5'd3, 5'd0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0001, 4'd4},
    // R7 equal operands give zero with carry
    '{5'd2, 5'd0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b1001, 4'd7},
    // R6 R4 = R1 + R4 + 1
    '{5'd4, 5'd1, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 16'h0000, 1'b1, 16'h8000, 4'b0110, 4'd6},
    // R10 read back
    '{5'd4, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h8000, 4'b0010, 4'd10},
    // R11 negative overflow on subtract
    '{5'd4, 5'd2, 1'b1, 1'b0, 2'd3, 2'd1, 1'b0, 16'h0000, 1'b0, 16'h7FFF, 4'b1100, 4'd11},
    // R3 write through regbField
    '{5'd0, 5'd5, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 16'h1234, 1'b1, 16'h1234, 4'b0000, 4'd3},
    '{5'd5, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h1234, 4'b0000, 4'd3},
    '{5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0001, 4'd3},
    // R2 A from regaField, then from regbField
    '{5'd2, 5'd5, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h0002, 4'b0000, 4'd2},
    '{5'd2, 5'd5, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, 16'h1235, 4'b0000, 4'd2}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] ra, input logic [4:0] rb, input logic aS,
                       input logic bS, input logic [1:0] fn, input logic [1:0] cs,
                       input logic ud, input logic [15:0] din, input logic wr,
                       input logic fe);
    regaField = ra; regbField = rb; aAddrSel = aS; bAddrSel = bS;
    funcSel = fn; cinSel = cs; bSrcSel = ud; dataIn = din; wrEn = wr; flagEn = fe;
  endtask

  function automatic logic [15:0] flags4();
    return {12'h000, flagC, flagV, flagS, flagZ};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0;
    drive(5'd1, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    // R1 reset state visible through pass function
    #1 check("R1 reg after reset", dOut, 16'h0000);
    check("R1 flags after reset", flags4(), 16'h0000);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].ra, VECS[i].rb, VECS[i].aS, VECS[i].bS, VECS[i].fn,
            VECS[i].cs, VECS[i].ud, VECS[i].din, VECS[i].wr, 1'b1);
      #1 check($sformatf("R%0d vec%0d out", VECS[i].req, i), dOut, VECS[i].expOut);
      @(posedge clk); #1;
      check($sformatf("R%0d vec%0d flags", VECS[i].req, i), flags4(), {12'h000, VECS[i].expFl});
    end

    // R10 write disabled: R1 keeps 0x7FFF
    @(negedge clk);
    drive(5'd1, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 16'hABCD, 1'b0, 1'b1);
    @(negedge clk);
    drive(5'd1, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b1);
    #1 check("R10 no write when disabled", dOut, 16'h7FFF);

    // R11 flags hold when flagEn low: set C via subtract then update disabled
    @(negedge clk);
    drive(5'd2, 5'd0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 16'h0, 1'b0, 1'b1);
    @(negedge clk);
    drive(5'd1, 5'd1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 16'h0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R11 flags held", flags4(), 16'h0009);

    // R1 reset mid-run clears registers and flags
    @(negedge clk);
    drive(5'd5, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b0);
    rstN = 1'b0;
    #1 check("R1 reg cleared by reset", dOut, 16'h0000);
    check("R1 flags cleared by reset", flags4(), 16'h0000);
    @(negedge clk) rstN = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule